// File: doc/BRIEF.md
# Spectrum-Peak Modulation Mode Selector

This block sits after a 1024-point radix-2 decimation-in-time transform of an idle channel. The samples fed to the transform are 16-bit fixed point with 15 fractional bits. The block receives that transform's magnitude bins one per accepted cycle, each tagged with its bin index and with a flag on the final bin of the frame. It tracks the strongest bin in the lower half of the spectrum, which is the half that carries information for a real input.

When the frame ends, the block decides which modulation scheme the transmitter should use and offers that decision as a 2-bit code over a valid/ready handshake:

- If the peak magnitude does not exceed a programmable noise threshold, the channel counts as quiet and amplitude keying is chosen.
- If the peak exceeds the threshold but lies away from both frequency-keying carrier bins, frequency keying is chosen.
- If the peak lies within a programmable bin window of either carrier bin, phase keying is chosen.

The two carrier bin positions are parameters. By default they are bins 64 and 128, which are 1 MHz and 2 MHz at a 16 MHz sample rate.

While a decision waits to be taken, no further bins are accepted. Once the decision is taken, the next frame is searched from scratch.

Top module: `spectral_mode_selector`

## Requirements
- R1: After reset, `mode_valid` is 0 and `bin_ready` is 1.
- R2: While `mode_valid` is 1, `bin_ready` is 0. Bins offered in that time have no effect on any later decision.
- R3: A bin accepted with `bin_last` set raises `mode_valid` on the next cycle. Until `mode_ready` is seen, `mode_valid` stays 1 and `mode_code` stays unchanged.
- R4: If the frame's peak magnitude is less than or equal to `noise_thresh` (unsigned), `mode_code` is 2'b00, amplitude keying.
- R5: If the peak magnitude is strictly greater than `noise_thresh`, and the peak bin differs from both carrier bins by more than `near_win` bins, `mode_code` is 2'b01, frequency keying.
- R6: If the peak magnitude is strictly greater than `noise_thresh`, and the peak bin is within `near_win` bins of either carrier bin (inclusive), `mode_code` is 2'b10, phase keying.
- R7: When several searched bins share the largest magnitude, the lowest bin index is the peak, whatever the order in which the bins arrive.
- R8: Bins with index 512 or above never become the peak. If a frame has no bins below 512, its peak magnitude counts as zero.
- R9: `mode_code` is never 2'b11 while `mode_valid` is 1.
- R10: A handshake (`mode_valid` and `mode_ready` both 1) drops `mode_valid` on the next cycle. The next frame's search starts with no memory of earlier frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bin_mag | input | MAG_W | Magnitude of the offered bin (unsigned) |
| bin_idx | input | IDX_W | Index of the offered bin |
| bin_valid | input | 1 | A bin is offered |
| bin_last | input | 1 | The offered bin closes the frame |
| bin_ready | output | 1 | Bins are being accepted |
| noise_thresh | input | MAG_W | Noise threshold; the peak must exceed it to count as noise |
| near_win | input | WIN_W | Half-width in bins of the window around each carrier |
| mode_code | output | 2 | Decision: 00 amplitude, 01 frequency, 10 phase |
| mode_valid | output | 1 | Decision pending |
| mode_ready | input | 1 | Consumer takes the decision |

## Verification
The main sweep uses a threshold of 1000 and a window of 3. It moves a single strong peak across every searched index 0 to 511. Each such frame also holds a weaker background bin and a larger mirror-half bin. This sweep separates the phase-keying window edges around both carriers from the frequency-keying region. It also shows that the mirror bins never win.

A second set places the peak at the threshold and one count either side of it. This separates "equal" from "greater" in the noise test.

Tie frames present equal maxima in both arrival orders, which shows that the lowest index is kept. One frame offers a strong in-window bin while a decision is pending, followed by a quiet frame. Another pair follows a strong near-carrier frame with a weaker off-carrier frame. Together these show that neither ignored bins nor an earlier frame's peak leak into a later decision.

// File: rtl/spectral_mode_selector.sv
`timescale 1ns/1ps
module spectral_mode_selector #(
  parameter int MAG_W          = 32,
  parameter int IDX_W          = 10,
  parameter int SEARCH_BINS    = 512,
  parameter int CARRIER_LO_BIN = 64,
  parameter int CARRIER_HI_BIN = 128,
  parameter int WIN_W          = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [MAG_W-1:0] bin_mag,
  input  logic [IDX_W-1:0] bin_idx,
  input  logic             bin_valid,
  input  logic             bin_last,
  output logic             bin_ready,
  input  logic [MAG_W-1:0] noise_thresh,
  input  logic [WIN_W-1:0] near_win,
  output logic [1:0]       mode_code,
  output logic             mode_valid,
  input  logic             mode_ready
);
  localparam int DIST_W = IDX_W + 1;
  localparam logic [DIST_W-1:0] LIMIT  = DIST_W'(SEARCH_BINS);
  localparam logic [IDX_W-1:0]  LO_IDX = IDX_W'(CARRIER_LO_BIN);
  localparam logic [IDX_W-1:0]  HI_IDX = IDX_W'(CARRIER_HI_BIN);

  localparam logic [1:0] CODE_AMP   = 2'b00;
  localparam logic [1:0] CODE_FREQ  = 2'b01;
  localparam logic [1:0] CODE_PHASE = 2'b10;

  logic             pend;
  logic             have;
  logic [MAG_W-1:0] best_mag;
  logic [IDX_W-1:0] best_idx;
  logic [1:0]       code_q;

  function automatic logic [DIST_W-1:0] gap(input logic [IDX_W-1:0] a,
                                            input logic [IDX_W-1:0] b);
    logic [DIST_W-1:0] ea, eb;
    ea = {1'b0, a};
    eb = {1'b0, b};
    return (ea >= eb) ? (ea - eb) : (eb - ea);
  endfunction

  wire take     = bin_valid && !pend;
  wire in_range = {1'b0, bin_idx} < LIMIT;
  wire better   = in_range && (!have || (bin_mag > best_mag) ||
                  ((bin_mag == best_mag) && (bin_idx < best_idx)));

  wire [MAG_W-1:0] cand_mag  = better ? bin_mag : best_mag;
  wire [IDX_W-1:0] cand_idx  = better ? bin_idx : best_idx;
  wire             cand_have = have || better;

  wire [DIST_W-1:0] win_ext = DIST_W'(near_win);
  wire noisy   = cand_have && (cand_mag > noise_thresh);
  wire near_lo = gap(cand_idx, LO_IDX) <= win_ext;
  wire near_hi = gap(cand_idx, HI_IDX) <= win_ext;

  wire [1:0] verdict = !noisy              ? CODE_AMP   :
                       (near_lo || near_hi) ? CODE_PHASE : CODE_FREQ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend     <= 1'b0;
      have     <= 1'b0;
      best_mag <= '0;
      best_idx <= '0;
      code_q   <= CODE_AMP;
    end else begin
      if (take) begin
        if (bin_last) begin
          pend     <= 1'b1;
          code_q   <= verdict;
          have     <= 1'b0;
          best_mag <= '0;
          best_idx <= '0;
        end else if (better) begin
          have     <= 1'b1;
          best_mag <= bin_mag;
          best_idx <= bin_idx;
        end
      end
      if (pend && mode_ready) pend <= 1'b0;
    end
  end

  assign bin_ready  = !pend;
  assign mode_valid = pend;
  assign mode_code  = code_q;
endmodule

// File: rtl/spectral_mode_selector_chk.sv
`timescale 1ns/1ps
module spectral_mode_selector_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bin_valid,
  input logic       bin_last,
  input logic       bin_ready,
  input logic [1:0] mode_code,
  input logic       mode_valid,
  input logic       mode_ready
);
  a_r3_last_raises_valid: assert property (@(posedge clk) disable iff (!rst_n)
    bin_valid && bin_ready && bin_last |=> mode_valid);

  a_r3_hold_until_taken: assert property (@(posedge clk) disable iff (!rst_n)
    mode_valid && !mode_ready |=> mode_valid && $stable(mode_code));

  a_r3_rise_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_valid) |-> $past(bin_valid && bin_ready && bin_last));

  a_r2_no_accept_pending: assert property (@(posedge clk) disable iff (!rst_n)
    mode_valid |-> !bin_ready);

  a_r9_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
    mode_valid |-> mode_code != 2'b11);

  a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
    mode_valid && mode_ready |=> !mode_valid);
endmodule

bind spectral_mode_selector spectral_mode_selector_chk chk_i (.*);

// File: tb/spectral_mode_selector_tb.sv
`timescale 1ns/1ps
module spectral_mode_selector_tb_top;
  localparam int MAG_W = 32;
  localparam int IDX_W = 10;
  localparam int WIN_W = 6;
  localparam int LO = 64;
  localparam int HI = 128;

  logic clk = 0;
  logic rst_n = 0;
  logic [MAG_W-1:0] bin_mag = '0;
  logic [IDX_W-1:0] bin_idx = '0;
  logic bin_valid = 0, bin_last = 0, mode_ready = 0;
  logic [MAG_W-1:0] noise_thresh = 32'd1000;
  logic [WIN_W-1:0] near_win = 6'd3;
  logic bin_ready, mode_valid;
  logic [1:0] mode_code;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  spectral_mode_selector #(.MAG_W(MAG_W), .IDX_W(IDX_W), .WIN_W(WIN_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .bin_mag(bin_mag), .bin_idx(bin_idx),
    .bin_valid(bin_valid), .bin_last(bin_last), .bin_ready(bin_ready),
    .noise_thresh(noise_thresh), .near_win(near_win), .mode_code(mode_code),
    .mode_valid(mode_valid), .mode_ready(mode_ready));

  task automatic check(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int expect_code(input int idx, input int mag, input int thr, input int w);
    int dl, dh;
    if (mag <= thr) return 0;
    dl = (idx > LO) ? idx - LO : LO - idx;
    dh = (idx > HI) ? idx - HI : HI - idx;
    return (dl <= w || dh <= w) ? 2 : 1;
  endfunction

  task automatic send(input int idx, input int mag, input bit last);
    @(negedge clk);
    bin_idx = IDX_W'(idx);
    bin_mag = MAG_W'(mag);
    bin_valid = 1;
    bin_last = last;
    @(posedge clk);
    @(negedge clk);
    bin_valid = 0;
    bin_last = 0;
  endtask

  task automatic collect(input int exp, input string tag);
    check(int'(mode_valid), 1, {tag, " valid"});
    check(int'(mode_code), exp, tag);
    mode_ready = 1;
    @(posedge clk);
    @(negedge clk);
    mode_ready = 0;
    check(int'(mode_valid), 0, "R10 release");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(int'(mode_valid), 0, "R1 valid after reset");
    check(int'(bin_ready), 1, "R1 ready after reset");

    // R4 quiet frame
    send(10, 500, 0); send(64, 900, 1);
    collect(0, "R4 quiet");

    // R5 R6 R8 sweep of peak position
    for (int p = 0; p < 512; p++) begin
      send((p + 256) % 512, 100, 0);
      send(p, 5000, 0);
      send(1023 - p, 60000, 1);
      collect(expect_code(p, 5000, 1000, 3), "R5/R6/R8 sweep");
    end

    // R4 R5 R6 threshold boundary
    for (int d = -1; d <= 1; d++) begin
      send(300, 1000 + d, 1);
      collect(expect_code(300, 1000 + d, 1000, 3), "R4/R5 threshold");
      send(67, 1000 + d, 1);
      collect(expect_code(67, 1000 + d, 1000, 3), "R4/R6 threshold");
    end

    // R8 only mirror bins
    send(600, 90000, 0); send(700, 90000, 1);
    collect(0, "R8 mirror only");

    // R7 ties in both orders
    send(200, 5000, 0); send(64, 5000, 1);
    collect(2, "R7 tie high first");
    send(64, 5000, 0); send(200, 5000, 1);
    collect(2, "R7 tie low first");
    send(300, 7000, 0); send(130, 7000, 1);
    collect(2, "R7 tie near lower");

    // R3 hold and R2 ignore while pending
    send(300, 4000, 1);
    for (int k = 0; k < 4; k++) begin
      check(int'(mode_valid), 1, "R3 held valid");
      check(int'(mode_code), 1, "R3 held code");
      check(int'(bin_ready), 0, "R2 ready low");
      bin_idx = 10'd64; bin_mag = 32'd99999; bin_valid = 1; bin_last = 1;
      @(posedge clk);
      @(negedge clk);
    end
    bin_valid = 0; bin_last = 0;
    collect(1, "R3 after hold");
    send(20, 10, 1);
    collect(0, "R2 ignored bins left no trace");

    // R10 fresh search
    send(64, 9000, 1);
    collect(2, "R10 first frame");
    send(300, 2000, 1);
    collect(1, "R10 second frame");

    // R6 window edges with a wider window
    near_win = 6'd10;
    send(HI + 10, 5000, 1);
    collect(2, "R6 wide edge in");
    send(HI + 11, 5000, 1);
    collect(1, "R5 wide edge out");
    send(LO - 10, 5000, 1);
    collect(2, "R6 wide low edge");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule